// File: doc/BRIEF.md
# Pseudo-SRAM Configuration Register Sequencer

This block sits between on-chip control logic and a pseudo-SRAM. It accesses the memory's configuration registers rather than its array. A one-cycle command names a register, says whether to write or read it, and carries a 16-bit value. The sequencer then drives an asynchronous register cycle on the memory pins. During that cycle the register-enable pin is held high, and the register select sits on address bits [19:18]. For a write, the value itself travels on the low address bits; the data bus is not used.

A read cycle returns the word that the memory puts on the data bus. After each successful write, the sequencer updates its own copies of the bus-configuration and refresh-configuration registers. Other logic can read those copies at any time without touching the memory.

The device-identification register is read-only. A write to it is refused at once and flagged, and no bus cycle is issued. The three phases of a cycle are counted in clocks by parameters: address setup, strobe width, and chip-enable high recovery.

Top module: `cfgreg_seq`

## Requirements
- R1: After reset the memory pins are idle (reg-enable 0; chip-enable, address-valid, write and output strobes all 1) and busy is 0. The bus-configuration copy reads 16'h9D1F: bit 15 = 1 (asynchronous mode), bits [13:11] = 011 (latency code 3), bits [5:4] = 01 (half drive). The refresh-configuration copy reads 16'h0010: bit 4 = 1 (deep power-down off), bits [2:0] = 000 (full-array refresh).
- R2: Command select 0 is refresh config, 1 is bus config and 2 is device ID. These drive address bits [19:18] to 00, 10 and 01 respectively. A write puts the value on address [15:0]; a read drives those bits 0. All other address bits are 0, and the address holds for the whole cycle.
- R3: On the clock after a command is accepted, reg-enable goes to 1 and chip-enable and address-valid go to 0. Both strobes stay high for exactly T_SETUP cycles.
- R4: In a write, address-valid returns to 1 and the write strobe is low for exactly T_PULSE cycles. The output strobe stays high throughout.
- R5: In a read, the output strobe is low for exactly T_PULSE cycles and the write strobe stays high. rd_data takes the data-bus value present in the last strobe cycle.
- R6: After the strobe, chip-enable is 1 and reg-enable is 0 for exactly T_CEHI cycles while busy stays 1. Busy is 1 from the cycle after acceptance until that recovery ends.
- R7: done pulses for one cycle, in the first cycle that busy is 0 again.
- R8: A write command with select 2, or any command with select 3, raises reject for one cycle on the next clock. It causes no pin activity, leaves busy low and leaves both copies unchanged.
- R9: A completed write to select 0 or 1 loads its value into the matching copy. Reads leave both copies unchanged.
- R10: cmd_valid is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_sel | input | 2 | Register select (0 refresh, 1 bus, 2 ID) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_value | input | 16 | Value to write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle refusal pulse |
| rd_data | output | 16 | Last register word read |
| bus_cfg | output | 16 | Bus-configuration copy |
| rfr_cfg | output | 16 | Refresh-configuration copy |
| mem_cre | output | 1 | Register-enable pin |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_addr | output | 22 | Memory address bus |
| mem_dq_in | input | 16 | Memory data bus, input side |

## Verification
A wrong phase state or a miscounted phase timer shows up as a setup, strobe or recovery window that is one cycle off. It is visible on the pins within the same command. A wrong select code or a latched value mix-up shows as a bad address on the first cycle after acceptance. A stale or misdirected copy update appears on bus_cfg or rfr_cfg by the done pulse, and a read of the same register later returns data that disagrees with it. A leaky reject path reveals itself as pin activity or a changed copy on the very next clock.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [1:0] {
        SEL_RFR = 2'd0,
        SEL_BUS = 2'd1,
        SEL_ID  = 2'd2,
        SEL_BAD = 2'd3
    } regsel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV
    } phase_e;

    // Code placed on the two register-select address bits
    function automatic logic [1:0] sel_code(regsel_e s);
        case (s)
            SEL_RFR: sel_code = 2'b00;
            SEL_BUS: sel_code = 2'b10;
            SEL_ID:  sel_code = 2'b01;
            default: sel_code = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // Counter never wraps below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfgseq_pkg::*;
#(
    parameter int          DW      = 16,
    parameter logic [15:0] BUS_RST = 16'h9D1F,
    parameter logic [15:0] RFR_RST = 16'h0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  regsel_e       wr_sel,
    input  logic [DW-1:0] wr_val,
    output logic [DW-1:0] bus_cfg,
    output logic [DW-1:0] rfr_cfg
);
    typedef struct packed {
        logic [DW-1:0] bus;
        logic [DW-1:0] rfr;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en && wr_sel == SEL_BUS) sh_d.bus = wr_val;
        if (wr_en && wr_sel == SEL_RFR) sh_d.rfr = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.bus <= DW'(BUS_RST);
            sh_q.rfr <= DW'(RFR_RST);
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bus_cfg = sh_q.bus;
    assign rfr_cfg = sh_q.rfr;

    a_r9_copies_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bus_cfg) && $stable(rfr_cfg)));

endmodule

// File: rtl/cfgreg_seq.sv
module cfgreg_seq
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int SEL_LSB = 18,
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_CEHI  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_sel,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_value,
    output logic              busy,
    output logic              done,
    output logic              reject,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_cfg,
    output logic [DATA_W-1:0] rfr_cfg,
    output logic              mem_cre,
    output logic              mem_ce_n,
    output logic              mem_adv_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int TMAX = (T_SETUP > T_PULSE) ?
                          ((T_SETUP > T_CEHI) ? T_SETUP : T_CEHI) :
                          ((T_PULSE > T_CEHI) ? T_PULSE : T_CEHI);
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        phase_e            ph;
        logic              wr;
        regsel_e           sel;
        logic [DATA_W-1:0] val;
        logic [ADDR_W-1:0] addr;
        logic              cre;
        logic              ce_n;
        logic              adv_n;
        logic              we_n;
        logic              oe_n;
        logic              done;
        logic              reject;
        logic [DATA_W-1:0] rd;
    } seq_t;

    seq_t          st_d, st_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;
    logic          sh_wr;
    regsel_e       req_sel;

    assign req_sel = regsel_e'(cmd_sel);

    cfg_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    cfg_shadow_bank #(.DW(DATA_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sh_wr),
        .wr_sel  (st_q.sel),
        .wr_val  (st_q.val),
        .bus_cfg (bus_cfg),
        .rfr_cfg (rfr_cfg)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.reject = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        sh_wr       = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (req_sel == SEL_BAD || (cmd_write && req_sel == SEL_ID)) begin
                        st_d.reject = 1'b1;
                    end else begin
                        st_d.ph    = PH_SETUP;
                        st_d.wr    = cmd_write;
                        st_d.sel   = req_sel;
                        st_d.val   = cmd_value;
                        st_d.addr  = '0;
                        st_d.addr[SEL_LSB +: 2] = sel_code(req_sel);
                        if (cmd_write) st_d.addr[DATA_W-1:0] = cmd_value;
                        st_d.cre   = 1'b1;
                        st_d.ce_n  = 1'b0;
                        st_d.adv_n = 1'b0;
                        tmr_load   = 1'b1;
                        tmr_val    = CW'(T_SETUP - 1);
                    end
                end
            end
            PH_SETUP: begin
                if (tmr_exp) begin
                    st_d.ph    = PH_STROBE;
                    st_d.adv_n = 1'b1;
                    st_d.we_n  = !st_q.wr;
                    st_d.oe_n  = st_q.wr;
                    tmr_load   = 1'b1;
                    tmr_val    = CW'(T_PULSE - 1);
                end
            end
            PH_STROBE: begin
                if (tmr_exp) begin
                    st_d.ph   = PH_RECOV;
                    if (st_q.wr) sh_wr = 1'b1;
                    else         st_d.rd = mem_dq_in;
                    st_d.we_n = 1'b1;
                    st_d.oe_n = 1'b1;
                    st_d.ce_n = 1'b1;
                    st_d.cre  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(T_CEHI - 1);
                end
            end
            default: begin
                if (tmr_exp) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ph     <= PH_IDLE;
            st_q.sel    <= SEL_RFR;
            st_q.ce_n   <= 1'b1;
            st_q.adv_n  <= 1'b1;
            st_q.we_n   <= 1'b1;
            st_q.oe_n   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.ph != PH_IDLE);
    assign done      = st_q.done;
    assign reject    = st_q.reject;
    assign rd_data   = st_q.rd;
    assign mem_cre   = st_q.cre;
    assign mem_ce_n  = st_q.ce_n;
    assign mem_adv_n = st_q.adv_n;
    assign mem_we_n  = st_q.we_n;
    assign mem_oe_n  = st_q.oe_n;
    assign mem_addr  = st_q.addr;

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    a_r3_strobe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && mem_cre && mem_adv_n));

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (mem_ce_n && !busy && !mem_cre));

    a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    a_r6_ce_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/cfgreg_seq_tb.sv
module cfgreg_seq_tb;
    localparam int T_SETUP = 2;
    localparam int T_PULSE = 3;
    localparam int T_CEHI  = 2;
    localparam logic [15:0] ID_WORD = 16'h0C1B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_sel = 2'd0;
    logic        cmd_write = 1'b0;
    logic [15:0] cmd_value = 16'h0;
    logic        busy, done, reject;
    logic [15:0] rd_data, bus_cfg, rfr_cfg;
    logic        mem_cre, mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n;
    logic [21:0] mem_addr;
    logic [15:0] mem_dq_in;

    logic [15:0] exp_bus = 16'h9D1F;
    logic [15:0] exp_rfr = 16'h0010;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cfgreg_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_write(cmd_write), .cmd_value(cmd_value), .busy(busy), .done(done),
        .reject(reject), .rd_data(rd_data), .bus_cfg(bus_cfg), .rfr_cfg(rfr_cfg),
        .mem_cre(mem_cre), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_in(mem_dq_in)
    );

    // Memory model for register reads
    always_comb begin
        mem_dq_in = 16'h5A5A;
        if (mem_cre && !mem_oe_n) begin
            case (mem_addr[19:18])
                2'b00:   mem_dq_in = exp_rfr;
                2'b10:   mem_dq_in = exp_bus;
                2'b01:   mem_dq_in = ID_WORD;
                default: mem_dq_in = 16'hBAD0;
            endcase
        end
    end

    function automatic logic [21:0] exp_addr(logic [1:0] s, logic w, logic [15:0] v);
        logic [21:0] a;
        a = '0;
        case (s)
            2'd0:    a[19:18] = 2'b00;
            2'd1:    a[19:18] = 2'b10;
            default: a[19:18] = 2'b01;
        endcase
        if (w) a[15:0] = v;
        return a;
    endfunction

    function automatic logic [15:0] exp_read(logic [1:0] s);
        return (s == 2'd0) ? exp_rfr : (s == 2'd1) ? exp_bus : ID_WORD;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic run_cmd(logic [1:0] s, logic w, logic [15:0] v, bit poke);
        int n_set, n_str, n_rec, n;
        logic [21:0] ea;
        logic [15:0] exp_rd;
        ea = exp_addr(s, w, v);
        exp_rd = exp_read(s);
        n_set = 0; n_str = 0; n_rec = 0; n = 0;
        cmd_valid = 1'b1; cmd_sel = s; cmd_write = w; cmd_value = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 accept raises cre", {31'd0, mem_cre}, 32'd1);
        chk("R6 busy after accept", {31'd0, busy}, 32'd1);
        while (busy && n < 40) begin
            if (poke && n == 1) begin
                cmd_valid = 1'b1; cmd_sel = 2'd1; cmd_write = 1'b1; cmd_value = ~v;
            end else begin
                cmd_valid = 1'b0;
            end
            if (!mem_ce_n) begin
                chk("R2 address", {10'd0, mem_addr}, {10'd0, ea});
                if (mem_we_n && mem_oe_n) begin
                    n_set++;
                    chk("R3 adv low in setup", {31'd0, mem_adv_n}, 32'd0);
                end else begin
                    n_str++;
                    chk(w ? "R4 write strobe" : "R5 read strobe",
                        {30'd0, mem_we_n, mem_oe_n}, w ? 32'd1 : 32'd2);
                end
            end else begin
                n_rec++;
                chk("R6 cre low in recovery", {31'd0, mem_cre}, 32'd0);
            end
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b0;
        chk("R3 setup length", n_set, T_SETUP);
        chk(w ? "R4 strobe length" : "R5 strobe length", n_str, T_PULSE);
        chk("R6 recovery length", n_rec, T_CEHI);
        chk("R7 done pulse", {31'd0, done}, 32'd1);
        if (w) begin
            if (s == 2'd0) exp_rfr = v;
            if (s == 2'd1) exp_bus = v;
        end else begin
            chk("R5 read data", rd_data, exp_rd);
        end
        chk("R9 bus copy", bus_cfg, exp_bus);
        chk("R9 refresh copy", rfr_cfg, exp_rfr);
        @(negedge clk);
        chk("R7 done single cycle", {31'd0, done}, 32'd0);
        chk("R10 no follow-on cycle", {31'd0, busy}, 32'd0);
    endtask

    task automatic run_reject(logic [1:0] s, logic w, logic [15:0] v);
        cmd_valid = 1'b1; cmd_sel = s; cmd_write = w; cmd_value = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 reject pulse", {31'd0, reject}, 32'd1);
        chk("R8 no bus cycle", {29'd0, busy, mem_ce_n, mem_cre}, 32'd2);
        @(negedge clk);
        chk("R8 reject single cycle", {31'd0, reject}, 32'd0);
        chk("R8 still idle", {31'd0, mem_ce_n}, 32'd1);
        chk("R8 bus copy kept", bus_cfg, exp_bus);
        chk("R8 refresh copy kept", rfr_cfg, exp_rfr);
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk("R1 pins idle", {26'd0, mem_cre, mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, busy},
            32'b011110);
        chk("R1 bus default", bus_cfg, 16'h9D1F);
        chk("R1 refresh default", rfr_cfg, 16'h0010);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {31'd0, busy}, 32'd0);

        // directed corners
        run_cmd(2'd2, 1'b0, 16'h0, 1'b0);       // ID read
        run_cmd(2'd1, 1'b0, 16'h0, 1'b0);       // bus default read
        run_cmd(2'd1, 1'b1, 16'h1D1F, 1'b0);    // bus write, burst mode bit 15 = 0
        run_cmd(2'd0, 1'b1, 16'h0001, 1'b1);    // refresh write with a command poked while busy
        run_cmd(2'd0, 1'b0, 16'hFFFF, 1'b0);    // read ignores value
        run_reject(2'd2, 1'b1, 16'h1234);
        run_reject(2'd3, 1'b0, 16'h0);
        run_reject(2'd3, 1'b1, 16'hFFFF);

        for (int i = 0; i < 40; i++) begin
            logic [1:0] s;
            logic w;
            logic [15:0] v;
            s = 2'($urandom % 4);
            w = 1'($urandom);
            v = 16'($urandom);
            if (s == 2'd3 || (s == 2'd2 && w)) run_reject(s, w, v);
            else run_cmd(s, w, v, 1'($urandom % 4 == 0));
        end
        finish_run();
    end
endmodule